// File: doc/BRIEF.md
# Opcode Register with Interrupt Trap Injection

This block holds the opcode of the instruction a microcoded processor is running, and it is the point where interrupts break into the instruction stream. Microcode pulses a load strobe when the next opcode is on the bus. Normally the register takes that byte on the clock edge. If an interrupt is pending and the interrupt-enable flag is set at that moment, the register is synchronously cleared instead. The next instruction decoded is then the reserved trap opcode 0, whose microcode saves state and enters the service routine.

The enable flag lives in the block as well. Microcode sets and clears it with two strobes, and a clear beats a set. The pending line is looked at only in a cycle where load is asserted. An interrupt can therefore only take effect between instructions and never in the middle of one. The trap code, which is 0 by default, and the opcode width are parameters.

Top module: `opcode_trap_reg`

## Requirements
- R1: While rst_n is low, opcode reads 0 and irq_enabled reads 0.
- R2: When op_load is 1 and irq_enabled or irq_pending is 0, opcode equals the bus_data value of that cycle after the next rising clock edge.
- R3: When op_load, irq_enabled and irq_pending are all 1, opcode becomes the trap code (default 0) after the next rising edge, whatever bus_data carries.
- R4: When op_load is 0, opcode keeps its value across the edge, whatever irq_pending, irq_enabled or bus_data do.
- R5: ie_set alone makes irq_enabled 1 after the next edge, and ie_clr alone makes it 0. With neither strobe asserted, the flag holds its value.
- R6: When ie_set and ie_clr are both 1 in one cycle, irq_enabled is 0 after the edge.
- R7: The fetch decision uses the enable value held before the edge. An ie_set in the same cycle as a load does not trap that load. An ie_clr in the same cycle as a load with an interrupt pending still traps it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | OP_W | Opcode byte presented on the data bus |
| op_load | input | 1 | Microcode strobe: fetch the next opcode |
| irq_pending | input | 1 | An interrupt request is waiting |
| ie_set | input | 1 | Microcode strobe: enable interrupts |
| ie_clr | input | 1 | Microcode strobe: disable interrupts (wins over ie_set) |
| opcode | output | OP_W | Current opcode |
| irq_enabled | output | 1 | Current interrupt-enable flag |

## Verification
The bench drives a load with a pending interrupt and a non-zero bus byte. A design that loaded the byte, or ORed it with the clear, would show that byte instead of the trap code. It raises the pending line in cycles without a load, which catches a register that sampled the interrupt at any time and so broke into an instruction. It puts set and clear of the enable flag in the same cycle, and puts each of them in the same cycle as a load. This exposes a design where set wins, or where the strobe bypasses the flag and reaches the fetch decision one cycle early. A long stretch of random strobes is then compared every clock against a behavioural model.

// File: rtl/opt_pkg.sv
package opt_pkg;

   // What the opcode register does on the coming edge
   typedef enum logic [1:0] {
      OPA_HOLD = 2'd0,
      OPA_LOAD = 2'd1,
      OPA_TRAP = 2'd2
   } op_action_e;

endpackage

// File: rtl/opt_ie_flag.sv
module opt_ie_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic en_o
);

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (clr_i) begin
         en_q <= 1'b0;          // clear has priority over set
      end else if (set_i) begin
         en_q <= 1'b1;
      end
   end

   assign en_o = en_q;

endmodule

// File: rtl/opt_fetch_gate.sv
module opt_fetch_gate
   import opt_pkg::*;
(
   input  logic       load_i,
   input  logic       en_i,
   input  logic       pend_i,
   output op_action_e action_o
);

   logic take_trap;

   // Pending only matters at an instruction boundary
   assign take_trap = load_i & en_i & pend_i;

   always_comb begin
      if (take_trap) begin
         action_o = OPA_TRAP;
      end else if (load_i) begin
         action_o = OPA_LOAD;
      end else begin
         action_o = OPA_HOLD;
      end
   end

endmodule

// File: rtl/opt_op_store.sv
module opt_op_store
   import opt_pkg::*;
#(
   parameter int OP_W      = 8,
   parameter int TRAP_CODE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  op_action_e      action_i,
   input  logic [OP_W-1:0] data_i,
   output logic [OP_W-1:0] op_o
);

   localparam logic [OP_W-1:0] TRAP_VAL = OP_W'(TRAP_CODE);

   logic [OP_W-1:0] op_q;

   generate
      if (TRAP_CODE == 0) begin : g_clear_style
         // Load enable plus synchronous clear
         logic sclr;
         logic ld;
         assign sclr = (action_i == OPA_TRAP);
         assign ld   = (action_i == OPA_LOAD);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               op_q <= '0;
            end else if (sclr) begin
               op_q <= '0;
            end else if (ld) begin
               op_q <= data_i;
            end
         end
      end else begin : g_const_style
         // Non-zero trap code: mux a constant onto the load path
         logic [OP_W-1:0] nxt;
         always_comb begin
            unique case (action_i)
               OPA_TRAP: nxt = TRAP_VAL;
               OPA_LOAD: nxt = data_i;
               default:  nxt = op_q;
            endcase
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               op_q <= '0;
            end else begin
               op_q <= nxt;
            end
         end
      end
   endgenerate

   assign op_o = op_q;

endmodule

// File: rtl/opcode_trap_reg.sv
module opcode_trap_reg
   import opt_pkg::*;
#(
   parameter int OP_W      = 8,
   parameter int TRAP_CODE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] bus_data,
   input  logic            op_load,
   input  logic            irq_pending,
   input  logic            ie_set,
   input  logic            ie_clr,
   output logic [OP_W-1:0] opcode,
   output logic            irq_enabled
);

   generate
      if (OP_W < 1) begin : g_bad_width
         $error("opcode_trap_reg: OP_W must be at least 1");
      end
      if (TRAP_CODE < 0 || TRAP_CODE >= (1 << OP_W)) begin : g_bad_trap
         $error("opcode_trap_reg: TRAP_CODE does not fit in OP_W bits");
      end
   endgenerate

   logic       en_w;
   op_action_e act_w;

   opt_ie_flag u_ie (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ie_set),
      .clr_i (ie_clr),
      .en_o  (en_w)
   );

   opt_fetch_gate u_gate (
      .load_i   (op_load),
      .en_i     (en_w),
      .pend_i   (irq_pending),
      .action_o (act_w)
   );

   opt_op_store #(
      .OP_W      (OP_W),
      .TRAP_CODE (TRAP_CODE)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .action_i (act_w),
      .data_i   (bus_data),
      .op_o     (opcode)
   );

   assign irq_enabled = en_w;

endmodule

// File: rtl/opcode_trap_reg_chk.sv
module opcode_trap_reg_chk #(
   parameter int OP_W      = 8,
   parameter int TRAP_CODE = 0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [OP_W-1:0] bus_data,
   input logic            op_load,
   input logic            irq_pending,
   input logic            ie_set,
   input logic            ie_clr,
   input logic [OP_W-1:0] opcode,
   input logic            irq_enabled
);

   localparam logic [OP_W-1:0] TRAP_VAL = OP_W'(TRAP_CODE);

   AST_LOAD_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_load && !(irq_enabled && irq_pending)) |=> (opcode == $past(bus_data))); // R2

   AST_TRAP_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_load && irq_enabled && irq_pending) |=> (opcode == TRAP_VAL)); // R3

   AST_OPCODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_load |=> $stable(opcode)); // R4

   AST_IE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_set && !ie_clr) |=> irq_enabled); // R5

   AST_IE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_set && !ie_clr) |=> $stable(irq_enabled)); // R5

   AST_IE_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ie_clr |=> !irq_enabled); // R6

   AST_SET_NO_EARLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_load && !irq_enabled && ie_set) |=> (opcode == $past(bus_data))); // R7

endmodule

bind opcode_trap_reg opcode_trap_reg_chk #(
   .OP_W      (OP_W),
   .TRAP_CODE (TRAP_CODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_data    (bus_data),
   .op_load     (op_load),
   .irq_pending (irq_pending),
   .ie_set      (ie_set),
   .ie_clr      (ie_clr),
   .opcode      (opcode),
   .irq_enabled (irq_enabled)
);

// File: tb/opcode_trap_reg_tb.sv
module opcode_trap_reg_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] bus_data = '0;
   logic         op_load = 1'b0;
   logic         irq_pending = 1'b0;
   logic         ie_set = 1'b0;
   logic         ie_clr = 1'b0;
   logic [W-1:0] opcode;
   logic         irq_enabled;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   opcode_trap_reg #(.OP_W(W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_data    (bus_data),
      .op_load     (op_load),
      .irq_pending (irq_pending),
      .ie_set      (ie_set),
      .ie_clr      (ie_clr),
      .opcode      (opcode),
      .irq_enabled (irq_enabled)
   );

   // Behavioural reference model
   int    m_op = 0;
   int    m_ie = 0;
   string op_tag = "R1";
   string ie_tag = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_op = 0;
         m_ie = 0;
         op_tag = "R1";
         ie_tag = "R1";
      end else begin
         if (op_load && irq_pending && ((ie_set && m_ie == 0) || (ie_clr && m_ie == 1)))
            op_tag = "R7";
         else if (op_load && m_ie == 1 && irq_pending)
            op_tag = "R3";
         else if (op_load)
            op_tag = "R2";
         else
            op_tag = "R4";
         if (op_load)
            m_op = (m_ie == 1 && irq_pending) ? 0 : int'(bus_data);
         if (ie_set && ie_clr) ie_tag = "R6";
         else if (ie_set || ie_clr) ie_tag = "R5";
         else ie_tag = "R5";
         if (ie_clr) m_ie = 0;
         else if (ie_set) m_ie = 1;
      end
   end

   always @(negedge clk) begin
      checks++;
      if (opcode !== W'(m_op)) begin
         errors++;
         $display("FAIL %s opcode: actual %h expected %h", op_tag, opcode, W'(m_op));
      end
      checks++;
      if (irq_enabled !== (m_ie == 1)) begin
         errors++;
         $display("FAIL %s irq_enabled: actual %b expected %b", ie_tag, irq_enabled, m_ie == 1);
      end
   end

   task automatic drive(input logic ld, input logic [W-1:0] d, input logic pnd,
                        input logic st, input logic cl);
      @(posedge clk);
      #1;
      op_load = ld; bus_data = d; irq_pending = pnd; ie_set = st; ie_clr = cl;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state held for several cycles with busy inputs
      op_load = 1'b1; bus_data = 8'hA5; irq_pending = 1'b1; ie_set = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      op_load = 1'b0; ie_set = 1'b0; irq_pending = 1'b0;
      // R2: plain loads with interrupts disabled, pending both ways
      drive(1, 8'h3C, 0, 0, 0);
      drive(1, 8'hC3, 1, 0, 0);
      // R4: pending without load does nothing
      drive(0, 8'hFF, 1, 0, 0);
      // R7: set in the same cycle as a load with pending: no trap yet
      drive(1, 8'h77, 1, 1, 0);
      // R4: enabled and pending, but no fetch
      drive(0, 8'h11, 1, 0, 0);
      drive(0, 8'h22, 1, 0, 0);
      // R3: trap with a non-zero bus byte
      drive(1, 8'hFF, 1, 0, 0);
      // R2: enabled, no pending
      drive(1, 8'h5A, 0, 0, 0);
      // R7: clear with load and pending still traps
      drive(1, 8'h99, 1, 0, 1);
      // R2: now disabled
      drive(1, 8'h42, 1, 0, 0);
      // R6: set and clear together
      drive(0, 8'h00, 0, 1, 0);
      drive(0, 8'h00, 0, 1, 1);
      drive(1, 8'h81, 1, 0, 0);
      // R5 and general: random traffic
      for (int i = 0; i < 2000; i++) begin
         drive($urandom_range(0, 1), W'($urandom), $urandom_range(0, 1),
               ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
      end
      drive(0, 8'h00, 0, 0, 0);
      @(posedge clk);
      @(negedge clk);
      #1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule